// File: doc/BRIEF.md
# SCSI Controller Register File

This block is the byte-wide software-facing register bank of a SCSI protocol controller. A single strobed port carries reads and writes, and one offset can mean different things in each direction. A write to any of the three transfer-count offsets stores a start count. A read from the same offsets returns the live 24-bit count. A 16-byte data FIFO sits behind one offset. A command offset takes command bytes. From each byte the block uses only the DMA flag and the flush and bus-reset codes.

The bus phase engine, target selection and data mover sit outside this block. Stub inputs stand in for them. These inputs set the phase and sequence-step fields, post interrupt causes, and step the live count down. The status register collects an interrupt bit, a sticky terminal-count bit and the phase field. A registered level output, `irq_o`, follows the interrupt bit. Reading the interrupt register hands its causes to software and clears them in the same access.

Top module: `scsi_regfile`

## Requirements
- R1: After reset, status, interrupt, sequence-step, command and live count all read 0. The FIFO is empty, config 1 (offset 8) reads 7 and `irq_o` is low.
- R2: Writes to offsets 0, 1 and 9 (count low, mid and high) store the start count and leave the live count unchanged. A command byte with bit 7 set copies the start count into the live count. Reads of offsets 0, 1 and 9 return the live count.
- R3: A DMA command whose start count is zero loads 0x010000 into the live count.
- R4: Status bit 4 (terminal count) sets only when the live count steps from a nonzero value to zero, and it then stays set. A write to offset 0 clears it. Stepping while the count is already zero leaves the count at 0 and does not set the bit.
- R5: The `phase_we` stub loads status bits 2:0 with the bus phase: 0 data-out, 1 data-in, 2 command, 3 status, 6 message-out, 7 message-in; 4 and 5 are reserved. The `seq_we` stub loads the sequence-step register at offset 6.
- R6: A read of offset 5 returns the interrupt register and clears it to zero. The same read clears status bit 7 and keeps status bits 4 and 2:0.
- R7: A nonzero `cause_set` ORs its bits into the interrupt register and sets status bit 7 at the next clock edge. `irq_o` is high exactly while status bit 7 is set.
- R8: Offset 9 reads the chip identifier (parameter, default 0xA2) until offset 9 has been written once. After that, offset 9 returns the live count high byte.
- R9: Offset 7 returns the FIFO byte count in bits 4:0.
- R10: A write to offset 2 pushes a byte only while the FIFO holds fewer than 16 bytes. A read of offset 2 pops bytes in write order. A read of an empty FIFO returns 0x00 and leaves the count at 0.
- R11: Command code 0x01 in bits 6:0 empties the FIFO.
- R12: Command code 0x03 in bits 6:0 sets interrupt bit 7 (bus reset) unless config 1 bit 6 is set.
- R13: A command byte with bit 7 clear leaves the live count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current access |
| phase_we | input | 1 | Stub: load the phase field |
| phase_in | input | 3 | Stub: bus phase value |
| seq_we | input | 1 | Stub: load the sequence-step register |
| seq_in | input | 3 | Stub: sequence-step value |
| cause_set | input | 8 | Stub: interrupt causes to post |
| cnt_step | input | 1 | Stub: decrement the live count by one |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is the terminal-count edge from the zero-start reload, since the live count must fall by 65,536 before the bit can set. The bench loads a zero start count and holds the step stub high for exactly that many cycles. It then checks that the bit is set and that further steps at zero change nothing. A sweep of small start counts checks that the bit stays clear one step before zero and sets on the final step. Interrupt clearing is checked with the terminal-count bit and a nonzero phase already set, so that the preserved bits are visible.

// File: rtl/scsi_regfile_pkg.sv
package scsi_regfile_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_CNT_MID = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_FIFO    = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_CMD     = 4'd3;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_INTR    = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_SEQ     = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_FLAGS   = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_CFG1    = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 4'd9;

    typedef enum logic [6:0] {
        OP_NOP     = 7'h00,
        OP_FLUSH   = 7'h01,
        OP_BUS_RST = 7'h03
    } cmd_op_e;

    localparam int STAT_INT_BIT = 7;
    localparam int STAT_TC_BIT  = 4;
    localparam int INTR_RST_BIT = 7;
    localparam int CFG1_NOREPORT_BIT = 6;
    localparam logic [DATA_W-1:0] CFG1_RESET = 8'h07;
endpackage

// File: rtl/scsi_byte_fifo.sv
module scsi_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [$clog2(DEPTH+1)-1:0] used
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != FULL_CNT) && !clear;
        do_pop  = pop && (st_q.cnt != '0) && !clear;
        if (clear) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wptr = (st_q.wptr == PTR_W'(DEPTH-1)) ? '0 : st_q.wptr + 1'b1;
            if (do_pop)  st_d.rptr = (st_q.rptr == PTR_W'(DEPTH-1)) ? '0 : st_q.rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wptr] <= push_data;
    end

    assign head = (st_q.cnt == '0) ? '0 : mem_q[st_q.rptr];
    assign used = st_q.cnt;

    assert_fifo_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        used <= FULL_CNT);
    assert_full_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (used == FULL_CNT && push && !pop && !clear) |=> used == FULL_CNT);
    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (used == '0 && pop && !push) |=> used == '0);
    assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> used == '0);
endmodule

// File: rtl/scsi_xfer_counter.sv
module scsi_xfer_counter #(
    parameter int CNT_W     = 24,
    parameter int ZERO_BITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             hit_zero
);
    localparam logic [CNT_W-1:0] ZERO_LOAD = CNT_W'(1) << ZERO_BITS;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)
            st_d.cnt = (load_val == '0) ? ZERO_LOAD : load_val;
        else if (step && st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
        hit_zero = (st_q.cnt != '0) && (st_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    assert_zero_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> count == ZERO_LOAD);
    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && count != '0) |=> count == $past(count) - 1'b1);
    assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count == '0) |=> count == '0);
endmodule

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
    import scsi_regfile_pkg::*;
(
    input  logic              issue,
    input  logic [DATA_W-1:0] cmd_byte,
    output logic              dma_reload,
    output logic              flush,
    output logic              bus_reset
);
    cmd_op_e op;

    always_comb begin
        op         = cmd_op_e'(cmd_byte[6:0]);
        dma_reload = issue && cmd_byte[7];
        flush      = issue && (op == OP_FLUSH);
        bus_reset  = issue && (op == OP_BUS_RST);
    end
endmodule

// File: rtl/scsi_regfile.sv
module scsi_regfile
    import scsi_regfile_pkg::*;
#(
    parameter int                CNT_W      = 24,
    parameter int                ZERO_BITS  = 16,
    parameter int                FIFO_DEPTH = 16,
    parameter logic [DATA_W-1:0] CHIP_ID    = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              phase_we,
    input  logic [2:0]        phase_in,
    input  logic              seq_we,
    input  logic [2:0]        seq_in,
    input  logic [DATA_W-1:0] cause_set,
    input  logic              cnt_step,
    output logic              irq_o
);
    localparam int FCNT_W = $clog2(FIFO_DEPTH+1);
    localparam logic [DATA_W-1:0] FLAG_MASK = 8'h1F;

    typedef struct packed {
        logic [CNT_W-1:0]  start;
        logic              hi_written;
        logic [DATA_W-1:0] cmd;
        logic              st_int;
        logic              st_tc;
        logic [2:0]        phase;
        logic [2:0]        seq;
        logic [DATA_W-1:0] intr;
        logic [DATA_W-1:0] cfg1;
        logic              irq;
    } regs_t;

    regs_t r_d, r_q;

    logic wr, rd, cmd_issue, intr_read;
    logic dma_reload, flush, bus_reset;
    logic [CNT_W-1:0] live_cnt;
    logic hit_zero;
    logic [DATA_W-1:0] fifo_head;
    logic [FCNT_W-1:0] fifo_used;
    logic [DATA_W-1:0] new_causes;
    logic [DATA_W-1:0] status_val;

    assign wr        = bus_sel && bus_we;
    assign rd        = bus_sel && !bus_we;
    assign cmd_issue = wr && (bus_addr == OFS_CMD);
    assign intr_read = rd && (bus_addr == OFS_INTR);

    scsi_cmd_decode u_dec (
        .issue      (cmd_issue),
        .cmd_byte   (bus_wdata),
        .dma_reload (dma_reload),
        .flush      (flush),
        .bus_reset  (bus_reset)
    );

    scsi_xfer_counter #(
        .CNT_W     (CNT_W),
        .ZERO_BITS (ZERO_BITS)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dma_reload),
        .load_val (r_q.start),
        .step     (cnt_step),
        .count    (live_cnt),
        .hit_zero (hit_zero)
    );

    scsi_byte_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .push      (wr && (bus_addr == OFS_FIFO)),
        .push_data (bus_wdata),
        .pop       (rd && (bus_addr == OFS_FIFO)),
        .head      (fifo_head),
        .used      (fifo_used)
    );

    always_comb begin
        r_d = r_q;
        new_causes = cause_set;
        if (bus_reset && !r_q.cfg1[CFG1_NOREPORT_BIT])
            new_causes[INTR_RST_BIT] = 1'b1;

        if (wr) begin
            case (bus_addr)
                OFS_CNT_LO:  r_d.start[7:0]   = bus_wdata;
                OFS_CNT_MID: r_d.start[15:8]  = bus_wdata;
                OFS_CNT_HI: begin
                    r_d.start[23:16] = bus_wdata;
                    r_d.hi_written   = 1'b1;
                end
                OFS_CMD:     r_d.cmd  = bus_wdata;
                OFS_CFG1:    r_d.cfg1 = bus_wdata;
                default: ;
            endcase
        end

        if (wr && bus_addr == OFS_CNT_LO) r_d.st_tc = 1'b0;
        if (hit_zero)                     r_d.st_tc = 1'b1;

        if (phase_we) r_d.phase = phase_in;
        if (seq_we)   r_d.seq   = seq_in;

        if (intr_read) begin
            r_d.intr   = '0;
            r_d.st_int = 1'b0;
        end
        r_d.intr = r_d.intr | new_causes;
        if (new_causes != '0) r_d.st_int = 1'b1;

        r_d.irq = r_d.st_int;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cfg1 <= CFG1_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        status_val = '0;
        status_val[STAT_INT_BIT] = r_q.st_int;
        status_val[STAT_TC_BIT]  = r_q.st_tc;
        status_val[2:0]          = r_q.phase;
        bus_rdata = '0;
        if (rd) begin
            case (bus_addr)
                OFS_CNT_LO:  bus_rdata = live_cnt[7:0];
                OFS_CNT_MID: bus_rdata = live_cnt[15:8];
                OFS_CNT_HI:  bus_rdata = r_q.hi_written ? live_cnt[23:16] : CHIP_ID;
                OFS_FIFO:    bus_rdata = fifo_head;
                OFS_CMD:     bus_rdata = r_q.cmd;
                OFS_STATUS:  bus_rdata = status_val;
                OFS_INTR:    bus_rdata = r_q.intr;
                OFS_SEQ:     bus_rdata = {5'b0, r_q.seq};
                OFS_FLAGS:   bus_rdata = DATA_W'(fifo_used) & FLAG_MASK;
                OFS_CFG1:    bus_rdata = r_q.cfg1;
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign irq_o = r_q.irq;

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == r_q.st_int);
    assert_cause_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_set != '0) |=> irq_o);
    assert_intr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_read && cause_set == '0 && !bus_reset) |=> (r_q.intr == '0) && !irq_o);
    assert_keep_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_read && !phase_we && !cnt_step && !dma_reload && !wr) |=>
            (r_q.st_tc == $past(r_q.st_tc)) && (r_q.phase == $past(r_q.phase)));
    assert_tc_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st_tc) |-> (live_cnt == '0) && ($past(live_cnt) != '0));
    assert_rst_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && r_q.cfg1[CFG1_NOREPORT_BIT] && cause_set == '0 && !intr_read)
            |=> r_q.intr[INTR_RST_BIT] == $past(r_q.intr[INTR_RST_BIT]));
    assert_no_reload_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && !bus_wdata[7] && !cnt_step) |=> live_cnt == $past(live_cnt));
endmodule

// File: tb/scsi_regfile_test.sv
`timescale 1ns/100ps
module scsi_regfile_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       bus_sel = 0, bus_we = 0;
    logic [3:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       phase_we = 0, seq_we = 0, cnt_step = 0;
    logic [2:0] phase_in = 0, seq_in = 0;
    logic [7:0] cause_set = 0;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    scsi_regfile uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .phase_we(phase_we), .phase_in(phase_in), .seq_we(seq_we), .seq_in(seq_in),
        .cause_set(cause_set), .cnt_step(cnt_step), .irq_o(irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rd_count(output int c);
        logic [7:0] lo, mid, hi;
        rd(4'd0, lo); rd(4'd1, mid); rd(4'd9, hi);
        c = {8'h0, hi, mid, lo};
    endtask

    task automatic step_n(input int n);
        @(negedge clk);
        cnt_step = 1;
        repeat (n) @(negedge clk);
        cnt_step = 0;
    endtask

    task automatic post_cause(input logic [7:0] c);
        @(negedge clk); cause_set = c;
        @(negedge clk); cause_set = 0;
    endtask

    task automatic set_phase(input logic [2:0] p);
        @(negedge clk); phase_we = 1; phase_in = p;
        @(negedge clk); phase_we = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(4'd4, v); check("R1 status", v, 0);
        rd(4'd5, v); check("R1 intr", v, 0);
        rd(4'd6, v); check("R1 seq", v, 0);
        rd(4'd3, v); check("R1 cmd", v, 0);
        rd(4'd7, v); check("R1 flags", v, 0);
        rd(4'd8, v); check("R1 cfg1", v, 7);
        rd(4'd0, v); check("R1 cnt lo", v, 0);
        check("R1 irq", irq_o, 0);
        // R8 chip id until first write
        rd(4'd9, v); check("R8 chip id", v, 8'hA2);
        rd(4'd9, v); check("R8 chip id again", v, 8'hA2);
        wr(4'd9, 8'h05);
        rd(4'd9, v); check("R8 after write", v, 0);

        // R2 separate start/live, R13 non-DMA no reload
        wr(4'd0, 8'h12); wr(4'd1, 8'h34);
        rd_count(c); check("R2 start not live", c, 0);
        wr(4'd3, 8'h00);
        rd_count(c); check("R13 nop no reload", c, 0);
        wr(4'd3, 8'h80);
        rd_count(c); check("R2 dma reload", c, 24'h053412);
        rd(4'd3, v); check("R2 cmd readback", v, 8'h80);

        // R3 zero start, R4 long countdown
        wr(4'd0, 0); wr(4'd1, 0); wr(4'd9, 0);
        wr(4'd3, 8'h80);
        rd_count(c); check("R3 zero start", c, 24'h010000);
        rd(4'd4, v); check("R4 tc clear before", v & 8'h10, 0);
        step_n(65535);
        rd_count(c); check("R4 one left", c, 1);
        rd(4'd4, v); check("R4 tc not yet", v & 8'h10, 0);
        step_n(1);
        rd(4'd4, v); check("R4 tc set 64k", v & 8'h10, 8'h10);
        step_n(5);
        rd_count(c); check("R4 floor", c, 0);
        rd(4'd4, v); check("R4 sticky", v & 8'h10, 8'h10);
        wr(4'd0, 0);
        rd(4'd4, v); check("R4 write lo clears", v & 8'h10, 0);
        step_n(3);
        rd(4'd4, v); check("R4 no set at zero", v & 8'h10, 0);

        // R4 sweep small starts
        for (int n = 1; n <= 12; n++) begin
            wr(4'd0, 8'(n));
            wr(4'd3, 8'h80);
            rd_count(c); check("R2 sweep reload", c, n);
            if (n > 1) begin
                step_n(n - 1);
                rd(4'd4, v); check("R4 sweep pre", v & 8'h10, 0);
            end
            step_n(1);
            rd_count(c); check("R4 sweep zero", c, 0);
            rd(4'd4, v); check("R4 sweep tc", v & 8'h10, 8'h10);
            wr(4'd0, 8'(n));
            rd(4'd4, v); check("R4 sweep clear", v & 8'h10, 0);
        end

        // R5 phase and sequence stubs
        for (int p = 0; p < 8; p++) begin
            set_phase(3'(p));
            rd(4'd4, v); check("R5 phase", v, p);
            @(negedge clk); seq_we = 1; seq_in = 3'(7 - p);
            @(negedge clk); seq_we = 0;
            rd(4'd6, v); check("R5 seq", v, 7 - p);
        end

        // R6 / R7 interrupt read and clear with TC and phase held
        wr(4'd0, 8'h01); wr(4'd3, 8'h80); step_n(1);
        set_phase(3'd3);
        check("R7 irq idle", irq_o, 0);
        post_cause(8'h18);
        check("R7 irq raised", irq_o, 1);
        rd(4'd4, v); check("R7 status int", v, 8'h93);
        post_cause(8'h01);
        rd(4'd5, v); check("R6 intr value", v, 8'h19);
        rd(4'd4, v); check("R6 status kept", v, 8'h13);
        check("R6 irq dropped", irq_o, 0);
        rd(4'd5, v); check("R6 intr cleared", v, 0);

        // R12 bus reset report and mask
        wr(4'd3, 8'h03);
        check("R12 irq", irq_o, 1);
        rd(4'd5, v); check("R12 rst bit", v, 8'h80);
        wr(4'd8, 8'h47);
        rd(4'd8, v); check("R12 cfg1 readback", v, 8'h47);
        wr(4'd3, 8'h03);
        check("R12 masked irq", irq_o, 0);
        rd(4'd5, v); check("R12 masked", v, 0);
        wr(4'd8, 8'h07);

        // R9 / R10 FIFO fill beyond depth
        for (int i = 1; i <= 20; i++) begin
            wr(4'd2, 8'(8'hA0 + i));
            rd(4'd7, v); check("R9 flags", v, (i > 16) ? 16 : i);
        end
        for (int i = 1; i <= 16; i++) begin
            rd(4'd2, v); check("R10 pop order", v, 8'hA0 + i);
            rd(4'd7, v); check("R9 flags drain", v, 16 - i);
        end
        rd(4'd2, v); check("R10 empty pop", v, 0);
        rd(4'd7, v); check("R10 empty count", v, 0);

        // R11 flush
        for (int i = 0; i < 5; i++) wr(4'd2, 8'(i + 1));
        rd(4'd7, v); check("R11 pre flush", v, 5);
        wr(4'd3, 8'h01);
        rd(4'd7, v); check("R11 flushed", v, 0);
        rd(4'd2, v); check("R11 pop after flush", v, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule